// File: doc/BRIEF.md
# Profiling Record Packet Writer

This block takes one captured profiling sample per handshake and writes it into a linear byte buffer as a self-describing record. A record is a run of typed packets: each packet begins with a one-byte header whose upper nibble names the packet class and whose low bits give the payload size code, followed by the payload bytes, least significant byte first. Every record closes with a terminating packet, so a reader can walk the buffer forwards packet by packet.

Software places the write pointer with a load strobe or rewinds it to the base pointer, and sets a limit pointer. Before starting a record the writer checks that the largest possible record would still end at or below the limit. If it would not, no byte is written, the sample is dropped and the full interrupt is raised. The interrupt holds, and every further sample is dropped, until software loads a new pointer or rewinds. An optional timestamp packet carries the value of a free-running cycle counter taken when the sample was accepted.

Top module: `rec_pkt_writer`

## Requirements
- R1: Packet headers are: PC address 0xB3, operation kind 0x40, issue counter 0x91, target address 0xB3, completion counter 0x91, event bits 0x51, timestamp 0x73, terminator 0x00. The upper nibble is the class and the low bits are log2 of the payload size, except that the terminator carries no payload.
- R2: Packets are written in this order: PC address, operation kind, dispatch-to-issue counter, target address, dispatch-to-complete counter, event bits, then the optional timestamp, then the terminator.
- R3: Every written record ends with the terminator byte 0x00, and the writer goes idle on the cycle after it.
- R4: When `ts_en` is high at acceptance, a timestamp packet holding the 64-bit cycle count (the number of clock edges since reset release, sampled before the accepting edge) is placed just before the terminator. The record is then 39 bytes long. Without it the record is 30 bytes long.
- R5: Payloads are little-endian. One byte is written per cycle at consecutive addresses starting at the pointer value at acceptance. `cur_ptr` advances by the record length.
- R6: A sample is written only if `cur_ptr + 39 <= buf_limit`. Otherwise no byte is written, `cur_ptr` is unchanged and `buf_full_irq` rises on the next cycle. No write address ever reaches `buf_limit`.
- R7: While `buf_full_irq` is high, offered samples are consumed and dropped. The interrupt is cleared by `ptr_load`, which sets `cur_ptr` to `ptr_load_val`, or by `ptr_rewind`, which sets it to `buf_base`.
- R8: `smp_ready` is low for exactly the cycles in which a record is being written. After reset `cur_ptr` is 0, `buf_full_irq` is low, `wr_en` is low and `smp_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample offered |
| smp_ready | output | 1 | Writer can take a sample |
| smp_pc | input | 64 | PC of the sampled operation |
| smp_kind | input | 8 | Operation kind code |
| smp_target | input | 64 | Target address with condition flags |
| smp_issue_cyc | input | 16 | Dispatch-to-issue cycle count |
| smp_done_cyc | input | 16 | Dispatch-to-complete cycle count |
| smp_events | input | 16 | Event bits |
| ts_en | input | 1 | Append timestamp packet to this record |
| buf_base | input | AW | Buffer base pointer |
| buf_limit | input | AW | Buffer limit pointer (exclusive) |
| ptr_load | input | 1 | Load write pointer, clear interrupt |
| ptr_load_val | input | AW | Value for pointer load |
| ptr_rewind | input | 1 | Rewind pointer to base, clear interrupt |
| wr_en | output | 1 | Byte write strobe |
| wr_addr | output | AW | Byte write address |
| wr_data | output | 8 | Byte write data |
| cur_ptr | output | AW | Current write pointer |
| buf_full_irq | output | 1 | Buffer-full interrupt |

## Verification
The hardest situation to reach is the exact edge of the fit check, where the pointer sits within a few bytes of the worst-case record size below the limit. A one-byte error there either truncates a record or refuses one that fits. The bench loads the pointer directly to every offset from 37 to 41 bytes below the limit and predicts, for each offset, whether the record is written or the interrupt is raised. For each refused case it then offers a second sample to confirm that the sample is dropped while the interrupt is held, before it clears the interrupt by each of the two means.

// File: rtl/rec_pkt_pkg.sv
package rec_pkt_pkg;

  typedef enum logic [2:0] {
    SL_PC, SL_KIND, SL_ISSUE, SL_TGT, SL_DONE, SL_EVT, SL_TS, SL_END
  } slot_e;

  typedef struct packed {
    logic [63:0] pc;
    logic [63:0] tgt;
    logic [63:0] stamp;
    logic [15:0] issue;
    logic [15:0] done;
    logic [15:0] events;
    logic [7:0]  kind;
    logic        ts_on;
  } rec_t;

  localparam int REC_MAX = 39;

  function automatic logic [7:0] hdr_of(slot_e s);
    case (s)
      SL_PC, SL_TGT:     return 8'hB3;
      SL_KIND:           return 8'h40;
      SL_ISSUE, SL_DONE: return 8'h91;
      SL_EVT:            return 8'h51;
      SL_TS:             return 8'h73;
      default:           return 8'h00;
    endcase
  endfunction

  // payload bytes after the header
  function automatic logic [3:0] pay_len(slot_e s);
    case (s)
      SL_PC, SL_TGT, SL_TS:      return 4'd8;
      SL_KIND:                   return 4'd1;
      SL_ISSUE, SL_DONE, SL_EVT: return 4'd2;
      default:                   return 4'd0;
    endcase
  endfunction

  function automatic logic [63:0] pay_val(slot_e s, rec_t r);
    case (s)
      SL_PC:    return r.pc;
      SL_KIND:  return {56'd0, r.kind};
      SL_ISSUE: return {48'd0, r.issue};
      SL_TGT:   return r.tgt;
      SL_DONE:  return {48'd0, r.done};
      SL_EVT:   return {48'd0, r.events};
      SL_TS:    return r.stamp;
      default:  return 64'd0;
    endcase
  endfunction

  function automatic logic [7:0] byte_at(slot_e s, logic [3:0] idx, rec_t r);
    logic [63:0] v;
    if (idx == 4'd0) return hdr_of(s);
    v = pay_val(s, r) >> ({2'b00, idx - 4'd1} * 6'd8);
    return v[7:0];
  endfunction

  function automatic slot_e slot_next(slot_e s, logic ts_on);
    if (s == SL_EVT && !ts_on) return SL_END;
    return slot_e'(s + 3'd1);
  endfunction

endpackage

// File: rtl/rec_stamp.sv
module rec_stamp #(
  parameter int TSW = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [TSW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + 1'b1;
  end
endmodule

// File: rtl/rec_space.sv
module rec_space
  import rec_pkt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          rewind,
  input  logic          step,
  input  logic          try_start,
  output logic [AW-1:0] ptr,
  output logic          fits,
  output logic          irq
);
  localparam logic [AW:0] NEED = (AW+1)'(REC_MAX);

  logic refuse;
  assign fits   = ({1'b0, ptr} + NEED) <= {1'b0, limit};
  assign refuse = try_start && !fits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr <= '0;
    else if (rewind) ptr <= base;
    else if (load)   ptr <= load_val;
    else if (step)   ptr <= ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              irq <= 1'b0;
    else if (rewind || load) irq <= 1'b0;
    else if (refuse)         irq <= 1'b1;
  end

  p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !rewind |=> ptr == $past(ptr) + 1'b1);
  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !load && !rewind |=> irq);
  p_refuse_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refuse && !load && !rewind |=> irq && ptr == $past(ptr));
endmodule

// File: rtl/rec_seq.sv
module rec_seq
  import rec_pkt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  rec_t       rec_in,
  output logic       busy,
  output logic [7:0] data,
  output logic       last_byte
);
  slot_e      slot;
  logic [3:0] idx;
  rec_t       rec;

  assign data      = byte_at(slot, idx, rec);
  assign last_byte = busy && slot == SL_END && idx == pay_len(slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= SL_PC;
      idx  <= '0;
      rec  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      slot <= SL_PC;
      idx  <= '0;
      rec  <= rec_in;
    end else if (busy) begin
      if (idx == pay_len(slot)) begin
        idx <= '0;
        if (slot == SL_END) busy <= 1'b0;
        else                slot <= slot_next(slot, rec.ts_on);
      end else begin
        idx <= idx + 4'd1;
      end
    end
  end

  p_end_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte |-> data == 8'h00);
  p_idle_after_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !start |=> !busy);
endmodule

// File: rtl/rec_pkt_writer.sv
module rec_pkt_writer
  import rec_pkt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [63:0]   smp_pc,
  input  logic [7:0]    smp_kind,
  input  logic [63:0]   smp_target,
  input  logic [15:0]   smp_issue_cyc,
  input  logic [15:0]   smp_done_cyc,
  input  logic [15:0]   smp_events,
  input  logic          ts_en,
  input  logic [AW-1:0] buf_base,
  input  logic [AW-1:0] buf_limit,
  input  logic          ptr_load,
  input  logic [AW-1:0] ptr_load_val,
  input  logic          ptr_rewind,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [AW-1:0] cur_ptr,
  output logic          buf_full_irq
);
  logic        busy, fits, try_start, accept, last_byte;
  logic [63:0] stamp;
  rec_t        rec_in;

  assign try_start = smp_valid && !busy && !buf_full_irq;
  assign accept    = try_start && fits;
  assign smp_ready = !busy;
  assign wr_en     = busy;
  assign wr_addr   = cur_ptr;

  always_comb begin
    rec_in        = '0;
    rec_in.pc     = smp_pc;
    rec_in.tgt    = smp_target;
    rec_in.stamp  = stamp;
    rec_in.issue  = smp_issue_cyc;
    rec_in.done   = smp_done_cyc;
    rec_in.events = smp_events;
    rec_in.kind   = smp_kind;
    rec_in.ts_on  = ts_en;
  end

  rec_stamp #(.TSW(64)) stamp_i (
    .clk(clk), .rst_n(rst_n), .count(stamp)
  );

  rec_space #(.AW(AW)) space_i (
    .clk(clk), .rst_n(rst_n), .base(buf_base), .limit(buf_limit),
    .load(ptr_load), .load_val(ptr_load_val), .rewind(ptr_rewind),
    .step(wr_en), .try_start(try_start), .ptr(cur_ptr), .fits(fits),
    .irq(buf_full_irq)
  );

  rec_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start(accept), .rec_in(rec_in),
    .busy(busy), .data(wr_data), .last_byte(last_byte)
  );

  p_ready_low_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !smp_ready);
  p_in_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> {1'b0, wr_addr} < {1'b0, buf_limit});
  p_full_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full_irq && !wr_en |=> !wr_en);
endmodule

// File: tb/rec_pkt_writer_tb.sv
module rec_pkt_writer_tb_top;
  localparam int AW = 10;
  localparam logic [AW-1:0] BASE  = 10'd16;
  localparam logic [AW-1:0] LIMIT = 10'd1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 1'b0, ts_en = 1'b0, ptr_load = 1'b0, ptr_rewind = 1'b0;
  logic [63:0] smp_pc = '0, smp_target = '0;
  logic [7:0]  smp_kind = '0;
  logic [15:0] smp_issue_cyc = '0, smp_done_cyc = '0, smp_events = '0;
  logic [AW-1:0] ptr_load_val = '0;
  logic smp_ready, wr_en, buf_full_irq;
  logic [AW-1:0] wr_addr, cur_ptr;
  logic [7:0] wr_data;

  int n_chk = 0, n_fail = 0;
  longint unsigned tb_cyc;
  logic [7:0] exp_b[0:63];
  string exp_tag[0:63];
  int exp_n;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) tb_cyc <= 0; else tb_cyc <= tb_cyc + 1;

  rec_pkt_writer #(.AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_pc(smp_pc), .smp_kind(smp_kind), .smp_target(smp_target),
    .smp_issue_cyc(smp_issue_cyc), .smp_done_cyc(smp_done_cyc),
    .smp_events(smp_events), .ts_en(ts_en), .buf_base(BASE),
    .buf_limit(LIMIT), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
    .ptr_rewind(ptr_rewind), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cur_ptr(cur_ptr), .buf_full_irq(buf_full_irq)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input [7:0] h, input [63:0] v, input int nb, input string tag);
    exp_b[exp_n] = h; exp_tag[exp_n] = "R1 R2"; exp_n++;
    for (int k = 0; k < nb; k++) begin
      exp_b[exp_n] = v[8*k +: 8]; exp_tag[exp_n] = tag; exp_n++;
    end
  endtask

  task automatic pulse_ctrl(input bit rew, input logic [AW-1:0] val);
    @(negedge clk);
    ptr_rewind = rew; ptr_load = !rew; ptr_load_val = val;
    @(negedge clk);
    ptr_rewind = 0; ptr_load = 0;
  endtask

  // offer one sample; expect_wr says whether a record should appear
  task automatic run_rec(input [63:0] pc, input [7:0] kind, input [63:0] tgt,
                         input [15:0] ci, input [15:0] cd, input [15:0] ev,
                         input bit ts, input bit expect_wr);
    logic [AW-1:0] start;
    longint unsigned stamp;
    int n;
    @(negedge clk);
    check(smp_ready == 1'b1, "R8 ready idle", smp_ready, 1);
    smp_valid = 1; smp_pc = pc; smp_kind = kind; smp_target = tgt;
    smp_issue_cyc = ci; smp_done_cyc = cd; smp_events = ev; ts_en = ts;
    stamp = tb_cyc; start = cur_ptr;
    @(negedge clk);
    smp_valid = 0;
    if (!expect_wr) begin
      check(wr_en == 1'b0, "R6 no write when full", wr_en, 0);
      check(buf_full_irq == 1'b1, "R6 R7 irq raised/held", buf_full_irq, 1);
      @(negedge clk);
      check(wr_en == 1'b0, "R7 dropped sample", wr_en, 0);
      check(cur_ptr == start, "R6 ptr unchanged", cur_ptr, start);
      return;
    end
    exp_n = 0;
    put(8'hB3, pc, 8, "R5");
    put(8'h40, {56'd0, kind}, 1, "R5");
    put(8'h91, {48'd0, ci}, 2, "R5");
    put(8'hB3, tgt, 8, "R5");
    put(8'h91, {48'd0, cd}, 2, "R5");
    put(8'h51, {48'd0, ev}, 2, "R5");
    if (ts) put(8'h73, stamp, 8, "R4");
    exp_b[exp_n] = 8'h00; exp_tag[exp_n] = "R3"; exp_n++;
    n = 0;
    while (wr_en && n < 64) begin
      check(smp_ready == 1'b0, "R8 ready low while writing", smp_ready, 0);
      check(wr_addr == start + AW'(n), "R5 address", wr_addr, start + AW'(n));
      if (n < exp_n) check(wr_data == exp_b[n], exp_tag[n], wr_data, exp_b[n]);
      n++;
      @(negedge clk);
    end
    check(n == exp_n, "R4 record length", n, exp_n);
    check(n == (ts ? 39 : 30), "R4 length rule", n, ts ? 39 : 30);
    check(cur_ptr == start + AW'(exp_n), "R5 ptr advance", cur_ptr, start + AW'(exp_n));
    check(buf_full_irq == 1'b0, "R7 irq low after write", buf_full_irq, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cur_ptr == 0, "R8 reset ptr", cur_ptr, 0);
    check(buf_full_irq == 0, "R8 reset irq", buf_full_irq, 0);
    check(wr_en == 0, "R8 reset wr_en", wr_en, 0);
    check(smp_ready == 1, "R8 reset ready", smp_ready, 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // sweep of patterns, both timestamp settings
    for (int t = 0; t < 2; t++)
      for (int k = 0; k < 4; k++)
        run_rec(64'h0123_4567_89AB_CDEF ^ (64'(k) << (8*k + 4)),
                8'(8'h11 * (k + 1) + t), ~(64'hF0E1_D2C3_B4A5_9687 + 64'(k)),
                16'(16'h0101 * (k + 2)), 16'(16'hA55A ^ (k << 3)),
                16'(16'h8001 >> k), t[0], 1'b1);

    // boundary sweep of the fit check
    for (int off = 37; off <= 41; off++) begin
      pulse_ctrl(1'b0, LIMIT - AW'(off));
      check(buf_full_irq == 0, "R7 load clears irq", buf_full_irq, 0);
      check(cur_ptr == LIMIT - AW'(off), "R7 load value", cur_ptr, LIMIT - AW'(off));
      run_rec(64'hDEAD_BEEF_0000_0000 + 64'(off), 8'h3C, 64'h1234, 16'd7, 16'd99,
              16'h00F0, 1'b1, off >= 39);
      if (off < 39)
        run_rec(64'h55, 8'h01, 64'h66, 16'd1, 16'd2, 16'd3, 1'b0, 1'b0);
    end

    // leftover 9 bytes after 30-byte record: refuse
    pulse_ctrl(1'b0, LIMIT - 10'd39);
    run_rec(64'hAAAA, 8'h02, 64'hBBBB, 16'd4, 16'd5, 16'd6, 1'b0, 1'b1);
    run_rec(64'hCCCC, 8'h03, 64'hDDDD, 16'd4, 16'd5, 16'd6, 1'b0, 1'b0);
    pulse_ctrl(1'b1, '0);
    check(buf_full_irq == 0, "R7 rewind clears irq", buf_full_irq, 0);
    check(cur_ptr == BASE, "R7 rewind to base", cur_ptr, BASE);
    run_rec(64'hFEED_FACE_CAFE_F00D, 8'hFF, 64'h1, 16'hFFFF, 16'h0, 16'hFFFF, 1'b1, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule